// File: doc/BRIEF.md
# Pin Interrupt Channel Controller

This block turns a bank of asynchronous digital pins into eight independent interrupt requests. Every pin first passes through a two-flop synchronizer. Each channel then picks one synchronized pin through its own select field and watches that pin for a condition chosen at run time. In edge mode the condition is a rising transition, a falling transition, or either one. In level mode it is the pin being high, the pin being low, or either.

In edge mode a detected transition sets a sticky status bit. The channel's request line shows that bit until software writes a one to clear it. In level mode nothing is latched, and the request line follows the qualified pin level. A single wake line is the OR of all request lines, so a power controller can leave a low-power state on any active condition.

Software sets up the channels and clears status over a minimal write/read register bus. Each channel has one configuration word at an address equal to its index. The status word sits at the address just after the last channel.

Top module: `pin_irq_top`

## Requirements
- R1: Each of the NUM_CH channels samples only the pin whose index is written in bits [5:0] of its configuration word (address = channel index). A change on any other pin has no effect on that channel. A select value at or above NUM_PINS reads as a constant low pin.
- R2: Pins are synchronized through two flops. A level-mode request changes two clock edges after the pin changes. An edge-mode request rises three clock edges after the pin transition.
- R3: With bit 8 = 0 (edge mode), bit 9 enables rising-edge detection and bit 10 enables falling-edge detection. Either one or both may be set.
- R4: With bit 8 = 1 (level mode), the request is high while the selected pin is high if bit 9 is set, and while it is low if bit 10 is set. No status bit is set in this mode.
- R5: In edge mode a detected edge sets status bit c, which is readable at address NUM_CH. In this mode, request line c equals status bit c.
- R6: wake is high exactly when at least one request line is high.
- R7: A write to address NUM_CH clears every status bit whose data bit is one. Zero bits leave their status unchanged. An edge that lands in the same cycle as its clear leaves the bit set.
- R8: A pin pulse that lasts one clock cycle is detected as an edge.
- R9: When a write changes a channel's pin select, the next comparison uses the new pin's sample as the previous value, so no false edge is reported.
- R10: After reset every configuration word is zero (edge mode, nothing enabled), all status bits are zero, and every request line and wake are low.
- R11: Reading a channel address returns its configuration with only bits [5:0], 8, 9 and 10 implemented. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NUM_PINS | Asynchronous digital pins |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (channel index, or NUM_CH for status) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | NUM_CH | Per-channel interrupt request |
| wake | output | 1 | OR of all interrupt requests |

## Verification
The bench keeps eight channels and narrows the pin bank to NUM_PINS = 8. This makes it practical to sweep every channel against every pin under all five condition settings: rising, falling, both edges, level high and level low. In each case it also toggles a neighbouring pin to show that the neighbour is ignored. The narrow bank also brings within reach the latency counts, the one-cycle pulse, the clear that collides with an edge, and a select change onto a pin that is already high. Every one of these is driven with cycle-exact timing.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    localparam int SEL_W     = 6;
    localparam int BIT_LEVEL = 8;
    localparam int BIT_EN_A  = 9;
    localparam int BIT_EN_B  = 10;

    // per-channel configuration; en_a = rise/high, en_b = fall/low
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             level;
        logic             en_a;
        logic             en_b;
    } chan_cfg_t;

    typedef struct packed {
        logic prev;
        logic stat;
    } chan_st_t;

    function automatic chan_cfg_t word_to_cfg(input logic [31:0] w);
        chan_cfg_t c;
        c.sel   = w[SEL_W-1:0];
        c.level = w[BIT_LEVEL];
        c.en_a  = w[BIT_EN_A];
        c.en_b  = w[BIT_EN_B];
        return c;
    endfunction

    function automatic logic [31:0] cfg_to_word(input chan_cfg_t c);
        logic [31:0] w;
        w              = '0;
        w[SEL_W-1:0]   = c.sel;
        w[BIT_LEVEL]   = c.level;
        w[BIT_EN_A]    = c.en_a;
        w[BIT_EN_B]    = c.en_b;
        return w;
    endfunction

endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
    parameter int W      = 64,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs import pin_irq_pkg::*; #(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic [NUM_CH-1:0]        stat,
    output chan_cfg_t [NUM_CH-1:0]   cfg,
    output logic [NUM_CH-1:0]        sel_chg,
    output logic [NUM_CH-1:0]        clr
);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_CH);

    typedef struct packed {
        chan_cfg_t [NUM_CH-1:0] cfg;
        logic [NUM_CH-1:0]      chg;
    } regs_st_t;

    regs_st_t  st_d, st_q;
    chan_cfg_t wcfg;
    logic      unused_wbits;

    assign unused_wbits = ^bus_wdata[31:BIT_EN_B+1];

    always_comb begin
        wcfg      = word_to_cfg(bus_wdata);
        st_d      = st_q;
        st_d.chg  = '0;
        clr       = '0;
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_wr && bus_addr == ADDR_W'(c)) begin
                st_d.cfg[c] = wcfg;
                st_d.chg[c] = (wcfg.sel != st_q.cfg[c].sel);
            end
            if (bus_addr == ADDR_W'(c)) begin
                bus_rdata = cfg_to_word(st_q.cfg[c]);
            end
        end
        if (bus_addr == STAT_ADDR) begin
            bus_rdata = 32'(stat);
            if (bus_wr) clr = bus_wdata[NUM_CH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg     = st_q.cfg;
    assign sel_chg = st_q.chg;
endmodule

// File: rtl/pin_irq_chan.sv
module pin_irq_chan import pin_irq_pkg::*; #(
    parameter int NUM_PINS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins,
    input  chan_cfg_t           cfg,
    input  logic                sel_chg,
    input  logic                clr,
    output logic                irq,
    output logic                stat
);
    chan_st_t st_d, st_q;
    logic     cur, rise, fall, hit;

    always_comb begin
        cur = 1'b0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (cfg.sel == SEL_W'(p)) cur = pins[p];
        end
        rise = cur & ~st_q.prev;
        fall = ~cur & st_q.prev;
        // after a select change the old sample belongs to another pin
        hit  = !cfg.level && !sel_chg &&
               ((rise && cfg.en_a) || (fall && cfg.en_b));
        st_d.prev = cur;
        st_d.stat = (st_q.stat & ~clr) | hit;
        if (cfg.level) irq = (cur && cfg.en_a) || (!cur && cfg.en_b);
        else           irq = st_q.stat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat = st_q.stat;
endmodule

// File: rtl/pin_irq_top.sv
module pin_irq_top import pin_irq_pkg::*; #(
    parameter int NUM_CH      = 8,
    parameter int NUM_PINS    = 64,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [NUM_CH-1:0]   irq,
    output logic                wake
);
    logic [NUM_PINS-1:0]    pins_s;
    chan_cfg_t [NUM_CH-1:0] cfg_w;
    logic [NUM_CH-1:0]      chg_w, clr_w, stat_w, lvl_w;

    pin_irq_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pins_s)
    );

    pin_irq_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stat(stat_w),
        .cfg(cfg_w), .sel_chg(chg_w), .clr(clr_w)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pin_irq_chan #(.NUM_PINS(NUM_PINS)) u_ch (
            .clk(clk), .rst_n(rst_n), .pins(pins_s), .cfg(cfg_w[c]),
            .sel_chg(chg_w[c]), .clr(clr_w[c]), .irq(irq[c]), .stat(stat_w[c])
        );
        assign lvl_w[c] = cfg_w[c].level;
    end

    assign wake = |irq;
endmodule

// File: rtl/pin_irq_chk.sv
module pin_irq_chk #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] irq,
    input logic              wake,
    input logic [NUM_CH-1:0] stat,
    input logic [NUM_CH-1:0] clr,
    input logic [NUM_CH-1:0] sel_chg,
    input logic [NUM_CH-1:0] lvl
);
    p_wake_or_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake == (irq != '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_p
        p_edge_irq_stat_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !lvl[c] |-> irq[c] == stat[c]);

        p_stat_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[c] && !clr[c]) |=> stat[c]);

        p_level_no_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl[c] && !stat[c]) |=> !stat[c]);

        p_selchg_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
            sel_chg[c] |=> stat[c] == ($past(stat[c]) & ~$past(clr[c])));
    end
endmodule

bind pin_irq_top pin_irq_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .wake(wake), .stat(stat_w),
    .clr(clr_w), .sel_chg(chg_w), .lvl(lvl_w)
);

// File: tb/sim_pin_irq_top.sv
`timescale 1ns/1ps
module sim_pin_irq_top;
    localparam int NCH = 8;
    localparam int NP  = 8;
    localparam int AW  = 4;
    localparam logic [AW-1:0] STAT = AW'(NCH);

    logic          clk = 0;
    logic          rst_n = 0;
    logic [NP-1:0] pin_in = '0;
    logic          bus_wr = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NCH-1:0] irq;
    logic          wake;

    int  n_run = 0, n_fail = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    pin_irq_top #(.NUM_CH(NCH), .NUM_PINS(NP), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wake(wake)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] mkcfg(input int pin, input bit lv, input bit ea, input bit eb);
        return 32'(pin) | (32'(lv) << 8) | (32'(ea) << 9) | (32'(eb) << 10);
    endfunction

    initial begin
        #400000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        cyc(3);
        rst_n = 1;
        cyc(2);

        // R10: reset state
        chk(irq == '0, "R10 irq", 32'(irq), 0);
        chk(wake == 0, "R10 wake", 32'(wake), 0);
        rd(STAT, r); chk(r == 0, "R10 status", r, 0);
        for (int a = 0; a < NCH; a++) begin
            rd(AW'(a), r); chk(r == 0, "R10 cfg", r, 0);
        end

        // R11: readback masks unimplemented bits
        wr(3, 32'hFFFF_FFFF);
        rd(3, r); chk(r == 32'h73F, "R11 readback", r, 32'h73F);
        wr(3, 32'h0000_0205);
        rd(3, r); chk(r == 32'h205, "R11 readback", r, 32'h205);
        wr(3, 0);

        // R1 R3 R4 R5 R6 R7: sweep channel x pin x mode
        for (int ch = 0; ch < NCH; ch++) begin
            for (int p = 0; p < NP; p++) begin
                for (int m = 0; m < 5; m++) begin
                    bit lv, ea, eb, e;
                    lv = (m >= 3);
                    ea = (m == 0) || (m == 2) || (m == 3);
                    eb = (m == 1) || (m == 2) || (m == 4);
                    pin_in = '0;
                    wr(STAT, 32'hFF);
                    cyc(3);
                    wr(AW'(ch), mkcfg(p, lv, ea, eb));
                    cyc(3);
                    e = lv ? eb : 1'b0;
                    chk(irq[ch] == e, "R4 idle", 32'(irq[ch]), 32'(e));
                    chk(wake == e, "R6 wake idle", 32'(wake), 32'(e));
                    pin_in[p] = 1; cyc(3);
                    e = ea;
                    chk(irq[ch] == e, lv ? "R4 high" : "R3 rise", 32'(irq[ch]), 32'(e));
                    chk(wake == e, "R6 wake", 32'(wake), 32'(e));
                    pin_in[(p+1)%NP] = 1; cyc(3);
                    chk(irq[ch] == e, "R1 other pin", 32'(irq[ch]), 32'(e));
                    pin_in[(p+1)%NP] = 0; cyc(3);
                    chk(irq[ch] == e, "R1 other pin", 32'(irq[ch]), 32'(e));
                    pin_in[p] = 0; cyc(3);
                    e = lv ? eb : 1'b1;
                    chk(irq[ch] == e, lv ? "R4 low" : "R3 fall", 32'(irq[ch]), 32'(e));
                    rd(STAT, r);
                    chk(r == (lv ? 0 : (32'd1 << ch)), "R5 status", r, lv ? 0 : (32'd1 << ch));
                    wr(STAT, 32'd1 << ch);
                    e = lv ? eb : 1'b0;
                    chk(irq[ch] == e, "R7 clear", 32'(irq[ch]), 32'(e));
                    wr(AW'(ch), 0);
                end
            end
        end

        // R2: latency of level and edge paths
        pin_in = '0;
        wr(1, mkcfg(3, 1, 1, 0));
        wr(0, mkcfg(3, 0, 1, 0));
        cyc(3);
        pin_in[3] = 1;
        cyc(1); chk(irq[1] == 0, "R2 level at 1", 32'(irq[1]), 0);
        cyc(1); chk(irq[1] == 1, "R2 level at 2", 32'(irq[1]), 1);
                chk(irq[0] == 0, "R2 edge at 2", 32'(irq[0]), 0);
        cyc(1); chk(irq[0] == 1, "R2 edge at 3", 32'(irq[0]), 1);
        pin_in = '0;
        wr(1, 0); wr(0, 0); cyc(3);
        wr(STAT, 32'hFF);

        // R8: one-cycle pulse
        wr(0, mkcfg(2, 0, 1, 0)); cyc(3);
        @(negedge clk) pin_in[2] = 1;
        @(negedge clk) pin_in[2] = 0;
        cyc(3);
        chk(irq[0] == 1, "R8 pulse", 32'(irq[0]), 1);
        wr(STAT, 32'hFF);
        chk(irq[0] == 0, "R8 cleared", 32'(irq[0]), 0);

        // R7: clear colliding with a new edge, and zero bits ignored
        wr(0, mkcfg(1, 0, 1, 1)); cyc(3);
        pin_in[1] = 1; cyc(3);
        chk(irq[0] == 1, "R7 set", 32'(irq[0]), 1);
        pin_in[1] = 0;
        cyc(2);
        bus_wr = 1; bus_addr = STAT; bus_wdata = 32'h1;
        @(negedge clk) bus_wr = 0;
        chk(irq[0] == 1, "R7 collide", 32'(irq[0]), 1);
        wr(STAT, 32'hFE);
        chk(irq[0] == 1, "R7 zero bit", 32'(irq[0]), 1);
        wr(STAT, 32'h1);
        chk(irq[0] == 0, "R7 clear after", 32'(irq[0]), 0);
        wr(0, 0); cyc(3);

        // R9: select change onto a pin already high
        pin_in = '0;
        wr(2, mkcfg(0, 0, 1, 0)); cyc(3);
        pin_in[5] = 1; cyc(3);
        wr(2, mkcfg(5, 0, 1, 0)); cyc(4);
        chk(irq[2] == 0, "R9 no false edge", 32'(irq[2]), 0);
        pin_in[5] = 0; cyc(3);
        pin_in[5] = 1; cyc(3);
        chk(irq[2] == 1, "R9 real edge", 32'(irq[2]), 1);
        wr(STAT, 32'hFF);

        // R1: select beyond the pin range reads low
        wr(4, mkcfg(40, 1, 0, 1));
        pin_in = '1; cyc(3);
        chk(irq[4] == 1, "R1 out of range", 32'(irq[4]), 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule